// File: doc/BRIEF.md
# Condition Field Unit

This block keeps a 32-bit condition register split into eight 4-bit fields, numbered 0 to 7. Each field has four flags, in this order: less-than (LT), greater-than (GT), equal (EQ) and summary overflow (SO). The bits are ordered most-significant first. Condition bit k sits at bit 31-k of the packed value, so field 0 takes the top nibble and its LT flag is bit 31.

Each accepted operation finishes in one clock. The block supports four operations:
- copy one field onto another;
- read out the whole packed register;
- load any set of fields from a 32-bit source value under an 8-bit field mask;
- move the top four bits of a 32-bit XER value into a field, returning the XER with those four bits cleared.

The field indices arrive as 5-bit instruction fields. Only their upper three bits select a field.

The register sits next to an instruction decoder. The decoder presents the operation, the field indices, the mask, the source value and the current XER on one cycle with `op_valid` high. On the next cycle the block returns the updated packed register, the updated XER and a one-cycle `done` pulse.

Top module: `crf_unit`

## Requirements
- R1: After reset, `packed_out` is 0, `xer_out` is 0 and `done` is 0.
- R2: `done` is high for exactly the one cycle that follows each cycle with `op_valid` high, and is low otherwise.
- R3: Condition bit k (k = 4·f + j, field f, flag j with LT=0, GT=1, EQ=2, SO=3) appears at `packed_out` bit 31-k, so field f occupies bits [31-4f:28-4f] with LT in the highest of them.
- R4: Operation code 0 (copy) writes the contents of the field chosen by `src_idx` into the field chosen by `dst_idx`; all other fields keep their values.
- R5: Operation code 1 (read) leaves the register unchanged and presents it on `packed_out`.
- R6: Operation code 2 (masked load) updates field f only when `field_mask` bit 7-f is set, and writes it with `src_value` bits [31-4f:28-4f] unchanged in order (source bit 31-4f becomes LT, source bit 28-4f becomes SO).
- R7: A masked load with a mask of zero leaves `packed_out` unchanged.
- R8: Operation code 3 (XER move) writes the target field with LT = `xer_in`[28], GT = `xer_in`[29], EQ = `xer_in`[30], SO = `xer_in`[31].
- R9: After an XER move, `xer_out` equals `xer_in` with bits [31:28] cleared.
- R10: After operation codes 0, 1 and 2, `xer_out` equals the `xer_in` value that came with the operation.
- R11: Field indices use only bits [4:2] of `dst_idx` and `src_idx`; bits [1:0] have no effect.
- R12: While `op_valid` is low, `packed_out` and `xer_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 2 | 0 copy, 1 read, 2 masked load, 3 XER move |
| dst_idx | input | 5 | Destination field index; bits [4:2] select the field |
| src_idx | input | 5 | Source field index for copy; bits [4:2] select the field |
| field_mask | input | 8 | Field enables for masked load; bit 7-f enables field f |
| src_value | input | 32 | Source value for masked load |
| xer_in | input | 32 | Current XER value |
| packed_out | output | 32 | Condition register after the last operation |
| xer_out | output | 32 | XER after the last operation |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bound checker watches, on every cycle, the properties that hold for any data:
- the `done` timing;
- the clearing of the top four XER bits and the pass-through of the rest of the XER;
- that reads, zero-mask loads, self-copies and idle cycles leave the register unchanged.

Some properties depend on particular values, and only the bench scenarios show them:
- the placement of bits within fields;
- which field a masked load or copy actually reaches;
- the reversed order of the XER summary bits inside the target field;
- that the low index bits are ignored.

The bench runs a chain of operations whose register state carries from one step to the next, then checks idle hold and a reset in the middle of a run.

// File: rtl/crf_pkg.sv
package crf_pkg;

   typedef enum logic [1:0] {
      CRF_COPY = 2'd0,
      CRF_READ = 2'd1,
      CRF_LOAD = 2'd2,
      CRF_XMOV = 2'd3
   } crf_op_e;

endpackage

// File: rtl/crf_field_copy.sv
module crf_field_copy #(
   parameter int NUM_FIELDS = 8,
   parameter int FIELD_W    = 4,
   parameter int SEL_W      = 3,
   localparam int DATA_W    = NUM_FIELDS * FIELD_W
) (
   input  logic [DATA_W-1:0] cr_i,
   input  logic [SEL_W-1:0]  dst_sel,
   input  logic [SEL_W-1:0]  src_sel,
   output logic [DATA_W-1:0] cr_o
);

   logic [FIELD_W-1:0] fld [NUM_FIELDS];
   logic [FIELD_W-1:0] src_nib;

   // field f sits at the top end for f = 0
   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_split
      assign fld[f] = cr_i[DATA_W-1-f*FIELD_W -: FIELD_W];
   end

   always_comb begin
      src_nib = '0;
      for (int f = 0; f < NUM_FIELDS; f++) begin
         if (src_sel == SEL_W'(f)) src_nib = fld[f];
      end
   end

   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_merge
      assign cr_o[DATA_W-1-f*FIELD_W -: FIELD_W] =
         (dst_sel == SEL_W'(f)) ? src_nib : fld[f];
   end

endmodule

// File: rtl/crf_mask_load.sv
module crf_mask_load #(
   parameter int NUM_FIELDS = 8,
   parameter int FIELD_W    = 4,
   localparam int DATA_W    = NUM_FIELDS * FIELD_W
) (
   input  logic [DATA_W-1:0]     cr_i,
   input  logic [NUM_FIELDS-1:0] mask,
   input  logic [DATA_W-1:0]     value,
   output logic [DATA_W-1:0]     cr_o
);

   // mask MSB enables field 0; nibble order is kept as given
   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
      localparam int HI = DATA_W - 1 - f * FIELD_W;
      assign cr_o[HI -: FIELD_W] = mask[NUM_FIELDS-1-f] ? value[HI -: FIELD_W]
                                                        : cr_i[HI -: FIELD_W];
   end

endmodule

// File: rtl/crf_xer_move.sv
module crf_xer_move #(
   parameter int NUM_FIELDS = 8,
   parameter int FIELD_W    = 4,
   parameter int SEL_W      = 3,
   parameter int XER_W      = 32,
   localparam int DATA_W    = NUM_FIELDS * FIELD_W
) (
   input  logic [DATA_W-1:0] cr_i,
   input  logic [SEL_W-1:0]  dst_sel,
   input  logic [XER_W-1:0]  xer_i,
   output logic [DATA_W-1:0] cr_o,
   output logic [XER_W-1:0]  xer_o
);

   logic [FIELD_W-1:0] summ;

   // lowest summary bit lands in the field's top flag
   for (genvar j = 0; j < FIELD_W; j++) begin : g_rev
      assign summ[FIELD_W-1-j] = xer_i[XER_W-FIELD_W+j];
   end

   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
      localparam int HI = DATA_W - 1 - f * FIELD_W;
      assign cr_o[HI -: FIELD_W] = (dst_sel == SEL_W'(f)) ? summ : cr_i[HI -: FIELD_W];
   end

   assign xer_o = {{FIELD_W{1'b0}}, xer_i[XER_W-FIELD_W-1:0]};

endmodule

// File: rtl/crf_unit.sv
module crf_unit #(
   parameter int NUM_FIELDS = 8,
   parameter int FIELD_W    = 4,
   parameter int IDX_W      = 5,
   parameter int XER_W      = 32,
   localparam int DATA_W    = NUM_FIELDS * FIELD_W,
   localparam int SEL_W     = $clog2(NUM_FIELDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [1:0]        op_code,
   input  logic [IDX_W-1:0]  dst_idx,
   input  logic [IDX_W-1:0]  src_idx,
   input  logic [NUM_FIELDS-1:0] field_mask,
   input  logic [DATA_W-1:0] src_value,
   input  logic [XER_W-1:0]  xer_in,
   output logic [DATA_W-1:0] packed_out,
   output logic [XER_W-1:0]  xer_out,
   output logic              done
);
   import crf_pkg::*;

   if (FIELD_W != 4) begin : g_bad_field_w
      $error("crf_unit: FIELD_W must be 4 (LT, GT, EQ, SO)");
   end
   if ((1 << SEL_W) != NUM_FIELDS) begin : g_bad_fields
      $error("crf_unit: NUM_FIELDS must be a power of two");
   end
   if (IDX_W < SEL_W + 2) begin : g_bad_idx_w
      $error("crf_unit: IDX_W too narrow for field select plus bit select");
   end
   if (XER_W <= FIELD_W) begin : g_bad_xer_w
      $error("crf_unit: XER_W must exceed FIELD_W");
   end

   crf_op_e           op;
   logic [SEL_W-1:0]  dst_sel, src_sel;
   logic [DATA_W-1:0] cr_q, cr_copy, cr_load, cr_xmov, cr_nxt;
   logic [XER_W-1:0]  xer_q, xer_xmov, xer_nxt;
   logic              done_q;

   assign op      = crf_op_e'(op_code);
   assign dst_sel = dst_idx[IDX_W-1 -: SEL_W];
   assign src_sel = src_idx[IDX_W-1 -: SEL_W];

   crf_field_copy #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W), .SEL_W(SEL_W)) i_copy (
      .cr_i    (cr_q),
      .dst_sel (dst_sel),
      .src_sel (src_sel),
      .cr_o    (cr_copy)
   );

   crf_mask_load #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) i_load (
      .cr_i  (cr_q),
      .mask  (field_mask),
      .value (src_value),
      .cr_o  (cr_load)
   );

   crf_xer_move #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W), .SEL_W(SEL_W),
                  .XER_W(XER_W)) i_xmov (
      .cr_i    (cr_q),
      .dst_sel (dst_sel),
      .xer_i   (xer_in),
      .cr_o    (cr_xmov),
      .xer_o   (xer_xmov)
   );

   always_comb begin
      cr_nxt  = cr_q;
      xer_nxt = xer_in;
      unique case (op)
         CRF_COPY: cr_nxt = cr_copy;
         CRF_READ: cr_nxt = cr_q;
         CRF_LOAD: cr_nxt = cr_load;
         CRF_XMOV: begin
            cr_nxt  = cr_xmov;
            xer_nxt = xer_xmov;
         end
         default:  cr_nxt = cr_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cr_q   <= '0;
         xer_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= op_valid;
         if (op_valid) begin
            cr_q  <= cr_nxt;
            xer_q <= xer_nxt;
         end
      end
   end

   assign packed_out = cr_q;
   assign xer_out    = xer_q;
   assign done       = done_q;

endmodule

// File: rtl/crf_unit_chk.sv
module crf_unit_chk #(
   parameter int NUM_FIELDS = 8,
   parameter int FIELD_W    = 4,
   parameter int IDX_W      = 5,
   parameter int XER_W      = 32,
   localparam int DATA_W    = NUM_FIELDS * FIELD_W,
   localparam int SEL_W     = $clog2(NUM_FIELDS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [1:0]        op_code,
   input logic [IDX_W-1:0]  dst_idx,
   input logic [IDX_W-1:0]  src_idx,
   input logic [NUM_FIELDS-1:0] field_mask,
   input logic [XER_W-1:0]  xer_in,
   input logic [DATA_W-1:0] packed_out,
   input logic [XER_W-1:0]  xer_out,
   input logic              done
);

   // R2
   done_after_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> done);

   // R2
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> !done);

   // R9
   xer_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 2'd3) |=>
         (xer_out[XER_W-1 -: FIELD_W] == '0) &&
         (xer_out[XER_W-FIELD_W-1:0] == $past(xer_in[XER_W-FIELD_W-1:0])));

   // R10
   xer_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code != 2'd3) |=> (xer_out == $past(xer_in)));

   // R5
   read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 2'd1) |=> $stable(packed_out));

   // R7
   mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 2'd2 && field_mask == '0) |=> $stable(packed_out));

   // R4
   self_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 2'd0 &&
       dst_idx[IDX_W-1 -: SEL_W] == src_idx[IDX_W-1 -: SEL_W]) |=> $stable(packed_out));

   // R12
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> ($stable(packed_out) && $stable(xer_out)));

endmodule

bind crf_unit crf_unit_chk #(
   .NUM_FIELDS (NUM_FIELDS),
   .FIELD_W    (FIELD_W),
   .IDX_W      (IDX_W),
   .XER_W      (XER_W)
) i_crf_unit_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .op_valid   (op_valid),
   .op_code    (op_code),
   .dst_idx    (dst_idx),
   .src_idx    (src_idx),
   .field_mask (field_mask),
   .xer_in     (xer_in),
   .packed_out (packed_out),
   .xer_out    (xer_out),
   .done       (done)
);

// File: tb/test_crf_unit.sv
module test_crf_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [1:0]  op_code = '0;
   logic [4:0]  dst_idx = '0;
   logic [4:0]  src_idx = '0;
   logic [7:0]  field_mask = '0;
   logic [31:0] src_value = '0;
   logic [31:0] xer_in = '0;
   logic [31:0] packed_out;
   logic [31:0] xer_out;
   logic        done;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   crf_unit i_crf_unit (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_valid   (op_valid),
      .op_code    (op_code),
      .dst_idx    (dst_idx),
      .src_idx    (src_idx),
      .field_mask (field_mask),
      .src_value  (src_value),
      .xer_in     (xer_in),
      .packed_out (packed_out),
      .xer_out    (xer_out),
      .done       (done)
   );

   // {op, dst, src, mask, value, xer_in, expected packed, expected xer}
   localparam int NV = 13;
   localparam logic [147:0] VEC [NV] = '{
      {2'd2, 5'd0,  5'd0,  8'hFF, 32'h12345678, 32'h00000000, 32'h12345678, 32'h00000000},
      {2'd0, 5'd28, 5'd0,  8'h00, 32'h00000000, 32'hAAAAAAAA, 32'h12345671, 32'hAAAAAAAA},
      {2'd2, 5'd0,  5'd0,  8'h41, 32'hFEDCBA98, 32'h00000000, 32'h1E345678, 32'h00000000},
      {2'd3, 5'd8,  5'd0,  8'h00, 32'h00000000, 32'h10000005, 32'h1E845678, 32'h00000005},
      {2'd3, 5'd23, 5'd0,  8'h00, 32'h00000000, 32'hC1234567, 32'h1E845378, 32'h01234567},
      {2'd1, 5'd0,  5'd0,  8'h00, 32'h00000000, 32'h87654321, 32'h1E845378, 32'h87654321},
      {2'd0, 5'd6,  5'd31, 8'h00, 32'h00000000, 32'h00000000, 32'h18845378, 32'h00000000},
      {2'd2, 5'd0,  5'd0,  8'h00, 32'hFFFFFFFF, 32'hF0000000, 32'h18845378, 32'hF0000000},
      {2'd0, 5'd12, 5'd12, 8'h00, 32'h00000000, 32'h00000000, 32'h18845378, 32'h00000000},
      {2'd2, 5'd0,  5'd0,  8'h80, 32'h00000000, 32'h00000000, 32'h08845378, 32'h00000000},
      {2'd3, 5'd0,  5'd0,  8'h00, 32'h00000000, 32'hFFFFFFFF, 32'hF8845378, 32'h0FFFFFFF},
      {2'd2, 5'd0,  5'd0,  8'h80, 32'h80000000, 32'h00000000, 32'h88845378, 32'h00000000},
      {2'd3, 5'd28, 5'd0,  8'h00, 32'h00000000, 32'h80000000, 32'h88845371, 32'h00000000}
   };

   function automatic string vtag(input int k);
      case (k)
         0:       return "R6";
         1:       return "R4 R10";
         2:       return "R6";
         3:       return "R8 R9";
         4:       return "R8 R11";
         5:       return "R5 R10";
         6:       return "R4 R11";
         7:       return "R7";
         8:       return "R4";
         9:       return "R3 R6";
         10:      return "R8 R9";
         11:      return "R3";
         default: return "R3 R8";
      endcase
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic [147:0] v);
      @(negedge clk);
      op_valid   = 1'b1;
      op_code    = v[147:146];
      dst_idx    = v[145:141];
      src_idx    = v[140:136];
      field_mask = v[135:128];
      src_value  = v[127:96];
      xer_in     = v[95:64];
      @(negedge clk);
      op_valid   = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "packed_out at reset", packed_out, 32'h0);
      check("R1", "xer_out at reset", xer_out, 32'h0);
      check("R1", "done at reset", {31'b0, done}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 no pulse without an operation
      check("R2", "done idle", {31'b0, done}, 32'h0);

      for (int k = 0; k < NV; k++) begin
         apply(VEC[k]);
         check(vtag(k), $sformatf("vector %0d packed_out", k), packed_out, VEC[k][63:32]);
         check(vtag(k), $sformatf("vector %0d xer_out", k), xer_out, VEC[k][31:0]);
         check("R2", $sformatf("vector %0d done pulse", k), {31'b0, done}, 32'h1);
         @(negedge clk);
         check("R2", $sformatf("vector %0d done falls", k), {31'b0, done}, 32'h0);
      end

      // R12 idle inputs that would change state if valid
      op_code    = 2'd2;
      field_mask = 8'hFF;
      src_value  = 32'h0;
      xer_in     = 32'h5A5A5A5A;
      repeat (4) @(negedge clk);
      check("R12", "packed_out idle", packed_out, 32'h88845371);
      check("R12", "xer_out idle", xer_out, 32'h0);
      check("R2", "done idle", {31'b0, done}, 32'h0);

      // R1 reset in mid-run
      rst_n = 1'b0;
      @(negedge clk);
      check("R1", "packed_out after reset", packed_out, 32'h0);
      check("R1", "xer_out after reset", xer_out, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule